// File: doc/BRIEF.md
# Typed Register Bank with Two-Level Interrupt Tree

This block is a small host-visible register file in which each address carries exactly one access behaviour. Some words are read-only views: fixed identity constants, or a live status input. One is a plain read/write control word that drives a core-facing output. One is a write-one strobe word. The rest form an interrupt tree: event-capturing alarm words, a per-bit enable word for each alarm word, a summary word, and an enable word for the summary. Core events set alarm bits, which stay set until the host clears them by writing 1. Each summary bit is the OR of one alarm word masked by its enables. The single interrupt pin is the registered OR of the enabled summary bits.

The host side is a synchronous port with an address, write data, a write strobe and a read strobe. Read data is registered. It appears one cycle after the read strobe and is zero in any cycle that follows no read. A soft-reset input returns the control word to its reset value and clears every enable. Captured alarms are left untouched, so no event is lost across a soft reset. The number of alarm words and the data width are parameters.

Address map (5-bit address): 0 identity constant, 1 revision constant, 2 live status, 3 control, 4 strobe, 5 summary, 6 summary enable, 8+2g alarm word g, 9+2g alarm enable word g. Every other address is unmapped.

Top module: `regbank_typed`

## Requirements
- R1: Reads of address 0 return ID_VALUE, reads of address 1 return REV_VALUE, and reads of address 2 return the value statusIn had in the read-strobe cycle.
- R2: ctrlOut holds the last value written to address 3 and changes only on such a write or on softRst, which loads CTRL_RESET. Hardware reset also loads CTRL_RESET.
- R3: A write to address 4 makes pulseOut equal to the written data for exactly the next cycle, after which it returns to 0. A read of address 4 returns 0.
- R4: Bit b of alarm word g (address 8+2g) is set by evtIn[g*DW+b] and stays set. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. Reset clears every alarm bit, and softRst does not change them.
- R5: If an event arrives in the same cycle as a write-1 clear of its alarm bit, the bit remains set.
- R6: Bit g of the summary word (address 5) is 1 exactly when some bit of alarm word g is 1 with its enable bit at address 9+2g also 1. A masked alarm still latches and reads back as 1.
- R7: irqOut is the registered OR of the summary bits ANDed with the summary enable (address 6, bit g for word g). It follows a change of these inputs one clock later.
- R8: All enable words reset to 0, and softRst clears them. softRst takes priority over a write in the same cycle.
- R9: Writes to addresses 0, 1, 2 and 5 have no effect. Reads of unmapped addresses return 0.
- R10: rdData is registered. It carries the value selected by the read strobe in the following cycle and is 0 after a cycle without a read strobe. A read in the same cycle as a write to the same address returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| softRst | input | 1 | Synchronous soft reset of control and enable words |
| addr | input | 5 | Host register address |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| wrData | input | DW | Host write data |
| rdData | output | DW | Registered host read data |
| statusIn | input | DW | Live status word from the core |
| evtIn | input | N_GRP*DW | Event inputs, word g in bits g*DW upward |
| ctrlOut | output | DW | Control word to the core |
| pulseOut | output | DW | One-cycle strobes to the core |
| irqOut | output | 1 | Top-level interrupt |

## Verification
The hardest case to reach from the ports is a core event and a host clear landing on the same alarm bit in the same cycle. The bench reaches it by driving the event vector together with the clearing write in one task call. The interrupt path is also awkward, because irqOut only moves when an alarm, its word enable and the summary enable line up. The bench therefore builds that chain one link at a time and reads the summary word between steps. Random traffic is then compared cycle by cycle against a behavioural model, so soft resets that collide with writes also get exercised.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int ADDR_W = 5;
  localparam int GIDX_W = 3;
  localparam int ALARM_BASE = 8;

  localparam logic [ADDR_W-1:0] A_ID      = 5'd0;
  localparam logic [ADDR_W-1:0] A_REV     = 5'd1;
  localparam logic [ADDR_W-1:0] A_STAT    = 5'd2;
  localparam logic [ADDR_W-1:0] A_CTRL    = 5'd3;
  localparam logic [ADDR_W-1:0] A_PULSE   = 5'd4;
  localparam logic [ADDR_W-1:0] A_SUMMARY = 5'd5;
  localparam logic [ADDR_W-1:0] A_SUMEN   = 5'd6;

  typedef enum logic [3:0] {
    RK_NONE, RK_ID, RK_REV, RK_STAT, RK_CTRL,
    RK_SUM, RK_SUMEN, RK_ALARM, RK_ALEN
  } rdKind_e;

  typedef struct packed {
    logic              rdEn;
    rdKind_e           rdKind;
    logic              wrCtrl;
    logic              wrPulse;
    logic              wrAlarm;
    logic              wrAlarmEn;
    logic              wrSumEn;
    logic [GIDX_W-1:0] grp;
  } strobe_t;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int N_GRP = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           stb
);
  localparam int GRP_END = ALARM_BASE + 2 * N_GRP;

  logic [ADDR_W-1:0] offset;
  logic              inGrp;

  always_comb begin
    offset = addr - ADDR_W'(ALARM_BASE);
    inGrp  = (int'(addr) >= ALARM_BASE) && (int'(addr) < GRP_END);
    stb           = '0;
    stb.rdEn      = rdEn;
    stb.rdKind    = RK_NONE;
    stb.grp       = offset[GIDX_W:1];
    case (addr)
      A_ID:      stb.rdKind = RK_ID;
      A_REV:     stb.rdKind = RK_REV;
      A_STAT:    stb.rdKind = RK_STAT;
      A_CTRL: begin
        stb.rdKind = RK_CTRL;
        stb.wrCtrl = wrEn;
      end
      A_PULSE:   stb.wrPulse = wrEn;
      A_SUMMARY: stb.rdKind = RK_SUM;
      A_SUMEN: begin
        stb.rdKind  = RK_SUMEN;
        stb.wrSumEn = wrEn;
      end
      default: begin
        if (inGrp) begin
          if (offset[0]) begin
            stb.rdKind    = RK_ALEN;
            stb.wrAlarmEn = wrEn;
          end else begin
            stb.rdKind  = RK_ALARM;
            stb.wrAlarm = wrEn;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/regbank_datapath.sv
module regbank_datapath
  import regbank_pkg::*;
#(
  parameter int          DW         = 8,
  parameter int          N_GRP      = 2,
  parameter logic [DW-1:0] ID_VALUE   = 8'hA7,
  parameter logic [DW-1:0] REV_VALUE  = 8'h03,
  parameter logic [DW-1:0] CTRL_RESET = 8'h5C
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softRst,
  input  strobe_t             stb,
  input  logic [DW-1:0]       wrData,
  input  logic [DW-1:0]       statusIn,
  input  logic [N_GRP*DW-1:0] evtIn,
  output logic [DW-1:0]       rdData,
  output logic [DW-1:0]       ctrlOut,
  output logic [DW-1:0]       pulseOut,
  output logic                irqOut
);
  logic [N_GRP-1:0][DW-1:0] alarm;
  logic [N_GRP-1:0][DW-1:0] alarmEn;
  logic [N_GRP-1:0]         summary;
  logic [N_GRP-1:0]         sumEn;
  logic [DW-1:0]            selAlarm;
  logic [DW-1:0]            selAlarmEn;
  logic [DW-1:0]            rdVal;

  for (genvar g = 0; g < N_GRP; g++) begin : gGrp
    logic          hit;
    logic [DW-1:0] clrMask;
    assign hit     = (stb.grp == GIDX_W'(g));
    assign clrMask = (stb.wrAlarm && hit) ? wrData : '0;

    // event set dominates the host clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) alarm[g] <= '0;
      else       alarm[g] <= (alarm[g] & ~clrMask) | evtIn[g*DW +: DW];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       alarmEn[g] <= '0;
      else if (softRst)                alarmEn[g] <= '0;
      else if (stb.wrAlarmEn && hit)   alarmEn[g] <= wrData;
    end

    assign summary[g] = |(alarm[g] & alarmEn[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlOut  <= CTRL_RESET;
      sumEn    <= '0;
      pulseOut <= '0;
      irqOut   <= 1'b0;
      rdData   <= '0;
    end else begin
      if (softRst)          ctrlOut <= CTRL_RESET;
      else if (stb.wrCtrl)  ctrlOut <= wrData;
      if (softRst)          sumEn <= '0;
      else if (stb.wrSumEn) sumEn <= wrData[N_GRP-1:0];
      pulseOut <= stb.wrPulse ? wrData : '0;
      irqOut   <= |(summary & sumEn);
      rdData   <= stb.rdEn ? rdVal : '0;
    end
  end

  always_comb begin
    selAlarm   = '0;
    selAlarmEn = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (stb.grp == GIDX_W'(g)) begin
        selAlarm   = alarm[g];
        selAlarmEn = alarmEn[g];
      end
    end
  end

  always_comb begin
    case (stb.rdKind)
      RK_ID:    rdVal = ID_VALUE;
      RK_REV:   rdVal = REV_VALUE;
      RK_STAT:  rdVal = statusIn;
      RK_CTRL:  rdVal = ctrlOut;
      RK_SUM:   rdVal = DW'(summary);
      RK_SUMEN: rdVal = DW'(sumEn);
      RK_ALARM: rdVal = selAlarm;
      RK_ALEN:  rdVal = selAlarmEn;
      default:  rdVal = '0;
    endcase
  end
endmodule

// File: rtl/regbank_typed.sv
module regbank_typed
  import regbank_pkg::*;
#(
  parameter int            DW         = 8,
  parameter int            N_GRP      = 2,
  parameter logic [DW-1:0] ID_VALUE   = 8'hA7,
  parameter logic [DW-1:0] REV_VALUE  = 8'h03,
  parameter logic [DW-1:0] CTRL_RESET = 8'h5C
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softRst,
  input  logic [4:0]          addr,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [DW-1:0]       wrData,
  output logic [DW-1:0]       rdData,
  input  logic [DW-1:0]       statusIn,
  input  logic [N_GRP*DW-1:0] evtIn,
  output logic [DW-1:0]       ctrlOut,
  output logic [DW-1:0]       pulseOut,
  output logic                irqOut
);
  strobe_t stb;

  regbank_decode #(.N_GRP(N_GRP)) decode_i (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .stb(stb)
  );

  regbank_datapath #(
    .DW(DW), .N_GRP(N_GRP), .ID_VALUE(ID_VALUE),
    .REV_VALUE(REV_VALUE), .CTRL_RESET(CTRL_RESET)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .stb(stb),
    .wrData(wrData), .statusIn(statusIn), .evtIn(evtIn),
    .rdData(rdData), .ctrlOut(ctrlOut), .pulseOut(pulseOut), .irqOut(irqOut)
  );
endmodule

// File: rtl/regbank_typed_chk.sv
module regbank_typed_chk #(
  parameter int            DW         = 8,
  parameter logic [DW-1:0] ID_VALUE   = 8'hA7,
  parameter logic [DW-1:0] CTRL_RESET = 8'h5C
) (
  input logic          clk,
  input logic          rstN,
  input logic          softRst,
  input logic [4:0]    addr,
  input logic          wrEn,
  input logic          rdEn,
  input logic [DW-1:0] rdData,
  input logic [DW-1:0] ctrlOut,
  input logic [DW-1:0] pulseOut,
  input logic          irqOut
);
  AST_ID_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 5'd0) |=> rdData == ID_VALUE); // R1
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!softRst && !(wrEn && addr == 5'd3)) |=> $stable(ctrlOut)); // R2
  AST_CTRL_SOFT: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> ctrlOut == CTRL_RESET); // R2
  AST_PULSE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == 5'd4) |=> pulseOut == '0); // R3
  AST_IRQ_SOFT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> ##1 !irqOut); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 5'd7) |=> rdData == '0); // R9
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> rdData == '0); // R10
endmodule

bind regbank_typed regbank_typed_chk #(
  .DW(DW), .ID_VALUE(ID_VALUE), .CTRL_RESET(CTRL_RESET)
) chk_i (
  .clk(clk), .rstN(rstN), .softRst(softRst), .addr(addr), .wrEn(wrEn),
  .rdEn(rdEn), .rdData(rdData), .ctrlOut(ctrlOut), .pulseOut(pulseOut),
  .irqOut(irqOut)
);

// File: tb/regbank_typed_tb_top.sv
module regbank_typed_tb_top;
  localparam int DW = 8;
  localparam int NG = 2;
  localparam logic [7:0] IDV = 8'hA7;
  localparam logic [7:0] REVV = 8'h03;
  localparam logic [7:0] CRST = 8'h5C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0;
  logic [4:0] addr = '0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] statusIn = 8'h5A;
  logic [15:0] evtIn = '0;
  logic [7:0] ctrlOut;
  logic [7:0] pulseOut;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regbank_typed #(.DW(DW), .N_GRP(NG), .ID_VALUE(IDV), .REV_VALUE(REVV),
    .CTRL_RESET(CRST)) dut_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .statusIn(statusIn),
    .evtIn(evtIn), .ctrlOut(ctrlOut), .pulseOut(pulseOut), .irqOut(irqOut)
  );

  // behavioural reference model
  logic [7:0] mAl [NG];
  logic [7:0] mEn [NG];
  logic [7:0] mCtrl, mPulse, mRd, mSumEn;
  logic       mIrq;

  function automatic logic [7:0] mSummary();
    logic [7:0] s = '0;
    for (int g = 0; g < NG; g++) if ((mAl[g] & mEn[g]) != 0) s[g] = 1'b1;
    return s;
  endfunction

  function automatic logic [7:0] mRead(logic [4:0] a);
    int ai = int'(a);
    if (ai == 0) return IDV;
    if (ai == 1) return REVV;
    if (ai == 2) return statusIn;
    if (ai == 3) return mCtrl;
    if (ai == 5) return mSummary();
    if (ai == 6) return mSumEn;
    for (int g = 0; g < NG; g++) begin
      if (ai == 8 + 2 * g) return mAl[g];
      if (ai == 9 + 2 * g) return mEn[g];
    end
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtrl = CRST; mPulse = 0; mRd = 0; mSumEn = 0; mIrq = 0;
      for (int g = 0; g < NG; g++) begin mAl[g] = 0; mEn[g] = 0; end
    end else begin
      logic [7:0] rdN;
      logic irqN;
      rdN  = rdEn ? mRead(addr) : 8'h00;
      irqN = (mSummary() & mSumEn) != 0;
      mPulse = (wrEn && addr == 5'd4) ? wrData : 8'h00;
      if (softRst) mCtrl = CRST;
      else if (wrEn && addr == 5'd3) mCtrl = wrData;
      if (softRst) mSumEn = 0;
      else if (wrEn && addr == 5'd6) mSumEn = {6'b0, wrData[1:0]};
      for (int g = 0; g < NG; g++) begin
        logic [7:0] clr;
        clr = (wrEn && int'(addr) == 8 + 2 * g) ? wrData : 8'h00;
        mAl[g] = (mAl[g] & ~clr) | evtIn[g*8 +: 8];
        if (softRst) mEn[g] = 0;
        else if (wrEn && int'(addr) == 9 + 2 * g) mEn[g] = wrData;
      end
      mRd = rdN;
      mIrq = irqN;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(rdData == mRd, "R10 rdData vs model", rdData, mRd);
      chk(irqOut == mIrq, "R7 irqOut vs model", irqOut, mIrq);
      chk(pulseOut == mPulse, "R3 pulseOut vs model", pulseOut, mPulse);
      chk(ctrlOut == mCtrl, "R2 ctrlOut vs model", ctrlOut, mCtrl);
    end
  end

  // one bus cycle, called at a falling edge, returns at the next one
  task automatic cyc(bit w, bit r, logic [4:0] a, logic [7:0] d,
                     logic [15:0] e, bit s);
    wrEn = w; rdEn = r; addr = a; wrData = d; evtIn = e; softRst = s;
    @(negedge clk);
    wrEn = 0; rdEn = 0; addr = 0; wrData = 0; evtIn = 0; softRst = 0;
  endtask

  task automatic rdChk(logic [4:0] a, logic [7:0] exp, string tag);
    cyc(0, 1, a, 0, 0, 0);
    chk(rdData == exp, tag, rdData, exp);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdData == 0 && irqOut == 0 && pulseOut == 0, "R10 reset outputs",
        {rdData, irqOut}, 0);
    chk(ctrlOut == CRST, "R2 reset ctrl", ctrlOut, CRST);

    rdChk(5'd0, IDV, "R1 id");
    rdChk(5'd1, REVV, "R1 rev");
    statusIn = 8'h3C;
    rdChk(5'd2, 8'h3C, "R1 live status");

    cyc(1, 0, 5'd3, 8'hC3, 0, 0);
    chk(ctrlOut == 8'hC3, "R2 ctrl write", ctrlOut, 8'hC3);
    rdChk(5'd3, 8'hC3, "R2 ctrl readback");
    cyc(0, 0, 0, 0, 16'hFFFF, 0);
    chk(ctrlOut == 8'hC3, "R2 events leave ctrl", ctrlOut, 8'hC3);
    cyc(1, 0, 5'd3, 8'h77, 0, 1);
    chk(ctrlOut == CRST, "R2 soft reset wins", ctrlOut, CRST);
    for (int g = 0; g < NG; g++) cyc(1, 0, 5'(8 + 2 * g), 8'hFF, 0, 0);

    cyc(1, 0, 5'd4, 8'h81, 0, 0);
    chk(pulseOut == 8'h81, "R3 pulse high", pulseOut, 8'h81);
    cyc(0, 0, 0, 0, 0, 0);
    chk(pulseOut == 8'h00, "R3 pulse drops", pulseOut, 0);
    rdChk(5'd4, 8'h00, "R3 pulse reads 0");

    cyc(0, 0, 0, 0, 16'h0004, 0);
    rdChk(5'd8, 8'h04, "R4 alarm latched");
    cyc(1, 0, 5'd8, 8'h00, 0, 0);
    rdChk(5'd8, 8'h04, "R4 write 0 keeps");
    cyc(1, 0, 5'd8, 8'h04, 0, 0);
    rdChk(5'd8, 8'h00, "R4 write 1 clears");
    cyc(0, 0, 0, 0, 16'h8000, 0);
    rdChk(5'd10, 8'h80, "R4 second word");
    cyc(1, 0, 5'd10, 8'h80, 0, 0);
    rdChk(5'd10, 8'h00, "R4 second word clear");

    cyc(0, 0, 0, 0, 16'h0002, 0);
    cyc(1, 0, 5'd8, 8'h02, 16'h0002, 0);
    rdChk(5'd8, 8'h02, "R5 event beats clear");

    rdChk(5'd5, 8'h00, "R6 masked summary");
    cyc(1, 0, 5'd9, 8'h02, 0, 0);
    rdChk(5'd5, 8'h01, "R6 enabled summary");
    chk(irqOut == 0, "R7 no irq without top enable", irqOut, 0);
    cyc(1, 0, 5'd6, 8'h01, 0, 0);
    chk(irqOut == 0, "R7 irq one cycle late", irqOut, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(irqOut == 1, "R7 irq asserted", irqOut, 1);

    cyc(0, 0, 0, 0, 0, 1);
    rdChk(5'd9, 8'h00, "R8 alarm enable cleared");
    rdChk(5'd6, 8'h00, "R8 summary enable cleared");
    chk(irqOut == 0, "R8 irq dropped", irqOut, 0);
    rdChk(5'd8, 8'h02, "R4 alarm survives soft reset");

    cyc(1, 0, 5'd0, 8'hFF, 0, 0);
    rdChk(5'd0, IDV, "R9 id unwritable");
    cyc(1, 0, 5'd2, 8'h00, 0, 0);
    rdChk(5'd2, 8'h3C, "R9 status unwritable");
    cyc(1, 0, 5'd5, 8'hFF, 0, 0);
    rdChk(5'd5, 8'h00, "R9 summary unwritable");
    rdChk(5'd7, 8'h00, "R9 unmapped 7");
    rdChk(5'd31, 8'h00, "R9 unmapped 31");

    cyc(1, 0, 5'd3, 8'h22, 0, 0);
    cyc(1, 1, 5'd3, 8'h11, 0, 0);
    chk(rdData == 8'h22, "R10 read before write", rdData, 8'h22);
    rdChk(5'd3, 8'h11, "R10 read after write");

    for (int i = 0; i < 2000; i++) begin
      logic [4:0] a;
      a = 5'($urandom_range(0, 13));
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
          8'($urandom), 16'($urandom) & 16'($urandom) & 16'($urandom),
          ($urandom_range(0, 40) == 0));
      if (i % 97 == 0) statusIn = 8'($urandom);
    end
    cyc(0, 0, 0, 0, 0, 0);
    finishRun();
  end
endmodule